// File: doc/BRIEF.md
# Cascadable Prescaled Timer Bank

This block holds four 16-bit up-counters. Each one has a reload value, a control word and a live count. A running timer advances in one of two ways. It can step once per prescaled base-clock period. In cascade mode it instead steps on each overflow of the timer one index below it. When a counter passes 0xFFFF it takes its reload value and, if its interrupt enable is set, raises a single-cycle request on its own bit of `irq`.

Software reaches the bank through simple write and read strobes. `haddr` is a halfword address: bit 0 picks the half of a timer and the upper bits pick the timer index. Half 0 is the count on reads and the reload value on writes. Half 1 is the control word. A 32-bit access (`wide` = 1) covers both halves of one timer. The count or reload sits in bits 15:0 and control sits in bits 31:16. A 16-bit access uses bits 15:0 of the data.

Top module: `tmr_bank`

## Requirements
- R1: After reset every count, reload and control word is zero, `irq` is 0000 and `rdata` is zero.
- R2: A read strobe returns its data on `rdata` in the cycle after the strobe. The data is sampled before that edge's counter update. For a 32-bit access at timer i (`haddr` = 2i), the count is in bits 15:0 and control in bits 31:16. A 16-bit read at `haddr` = 2i+1 returns control in bits 15:0 with zeros above.
- R3: A write to half 0 (`haddr` = 2i) changes only the reload value. The live count stays as it was.
- R4: The control fields are: bits 1:0 select the tick period (0 gives 2, 1 gives 128, 2 gives 512, 3 gives 2048 base cycles), bit 2 is cascade, bit 6 is interrupt enable and bit 7 is run. All other bits read back as zero.
- R5: When run goes from 0 to 1 with cascade clear, the count loads from reload at that write edge. If the same 32-bit write carries a new reload, that new value is loaded. The prescaler restarts, so the first step lands exactly P edges after the write edge, and a further step every P edges.
- R6: Clearing run freezes the count. Any partial prescaler period is discarded, so a later start waits a full period before its first step.
- R7: A step taken at 0xFFFF loads the reload value instead of wrapping to zero.
- R8: An overflow with interrupt enable set drives that timer's `irq` bit high for exactly one cycle, right after the overflow edge. With interrupt enable clear, the bit stays low.
- R9: A timer with both run and cascade set steps once per overflow of the timer below, on the same edge. This chaining passes through several timers on one edge.
- R10: A rising edge of run with cascade set leaves the count unchanged. Such a timer ignores its prescaler.
- R11: A control write that keeps run at 1 does not reload the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| haddr | input | 3 | Halfword address: {timer index, half} |
| wide | input | 1 | 1 selects a 32-bit access to both halves |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 4 | One-cycle overflow requests, one bit per timer |

## Verification
A wrong prescaler phase shows as a count that steps one edge early or late. The bench therefore reads a counter on the two edges that straddle the expected step, both right after a start and after a stop and restart. A broken reload or overflow path appears at the port within one read: the count after a wrap differs from the reload value, or the `irq` bit is missing or lasts more than one cycle. Faults in the cascade chain show as wrong counts in the upper timers, or as `irq` bits that do not fire together on the same edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int HALF_W = 16;
  localparam int B_SEL  = 0;
  localparam int B_CAS  = 2;
  localparam int B_IE   = 6;
  localparam int B_RUN  = 7;
  localparam logic [HALF_W-1:0] CTL_KEEP = 16'h00C7;

  function automatic int unsigned tick_period(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2;
      2'd1:    return 128;
      2'd2:    return 512;
      default: return 2048;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int DIV_W = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] last;

  always_comb last = DIV_W'(tick_period(sel) - 32'd1);

  assign tick = run && (phase_q >= last);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) phase_q <= '0;
    else if (tick)              phase_q <= '0;
    else                        phase_q <= phase_q + 1'b1;
  end

  // R5: a tick is followed by a full fresh period, never a second tick at once
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DIV_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_reload,
  input  logic              wr_ctrl,
  input  logic [HALF_W-1:0] reload_wdata,
  input  logic [HALF_W-1:0] ctrl_wdata,
  input  logic              casc_in,
  output logic [HALF_W-1:0] cnt_o,
  output logic [HALF_W-1:0] ctrl_o,
  output logic              ovf_o,
  output logic              irq_o
);
  logic [HALF_W-1:0] cnt_q, reload_q, ctrl_q, reload_nx;
  logic              irq_q;
  logic              running, start_edge, tick, inc;

  assign running    = ctrl_q[B_RUN];
  assign start_edge = wr_ctrl && !ctrl_q[B_RUN] && ctrl_wdata[B_RUN];

  tmr_prescaler #(.DIV_W(DIV_W)) i_presc (
    .clk     (clk),
    .rst     (rst),
    .restart (start_edge),
    .run     (running && !ctrl_q[B_CAS]),
    .sel     (ctrl_q[B_SEL+1:B_SEL]),
    .tick    (tick)
  );

  assign inc       = running && (ctrl_q[B_CAS] ? casc_in : tick);
  assign ovf_o     = inc && (cnt_q == '1);
  assign reload_nx = wr_reload ? reload_wdata : reload_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= '0;
      ctrl_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      reload_q <= reload_nx;
      if (wr_ctrl) ctrl_q <= ctrl_wdata & CTL_KEEP;
      if (start_edge && !ctrl_wdata[B_CAS]) cnt_q <= reload_nx;
      else if (inc)                         cnt_q <= ovf_o ? reload_q : cnt_q + 1'b1;
      irq_q <= ovf_o && ctrl_q[B_IE];
    end
  end

  assign cnt_o  = cnt_q;
  assign ctrl_o = ctrl_q;
  assign irq_o  = irq_q;

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($past(cnt_q) == '1) && $past(ctrl_q[B_IE]));

  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);

  p_wrap_reload_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !wr_ctrl) |=> cnt_q == $past(reload_q));

  p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (!running && !start_edge) |=> $stable(cnt_q));

  p_reload_only_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_reload && !wr_ctrl && !inc) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int NUM    = 4,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             haddr,
  input  logic                          wide,
  input  logic [2*HALF_W-1:0]           wdata,
  input  logic [NUM-1:0][HALF_W-1:0]    cnt_i,
  input  logic [NUM-1:0][HALF_W-1:0]    ctrl_i,
  output logic [NUM-1:0]                wr_reload,
  output logic [NUM-1:0]                wr_ctrl,
  output logic [HALF_W-1:0]             reload_wdata,
  output logic [HALF_W-1:0]             ctrl_wdata,
  output logic [2*HALF_W-1:0]           rdata
);
  localparam int IDX_W = ADDR_W - 1;

  logic [IDX_W-1:0]    idx;
  logic                hi;
  logic [HALF_W-1:0]   cnt_sel, ctl_sel;
  logic [2*HALF_W-1:0] rdata_q;

  assign idx = haddr[ADDR_W-1:1];
  assign hi  = haddr[0];

  for (genvar g = 0; g < NUM; g++) begin : g_dec
    assign wr_reload[g] = wr_en && (idx == IDX_W'(g)) && (wide || !hi);
    assign wr_ctrl[g]   = wr_en && (idx == IDX_W'(g)) && (wide || hi);
  end

  assign reload_wdata = wdata[HALF_W-1:0];
  assign ctrl_wdata   = wide ? wdata[2*HALF_W-1:HALF_W] : wdata[HALF_W-1:0];

  always_comb begin
    cnt_sel = '0;
    ctl_sel = '0;
    for (int i = 0; i < NUM; i++) begin
      if (idx == IDX_W'(i)) begin
        cnt_sel = cnt_i[i];
        ctl_sel = ctrl_i[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd_en) begin
      if (wide)    rdata_q <= {ctl_sel, cnt_sel};
      else if (hi) rdata_q <= {{HALF_W{1'b0}}, ctl_sel};
      else         rdata_q <= {{HALF_W{1'b0}}, cnt_sel};
    end
  end

  assign rdata = rdata_q;

  // R2: one access never reaches two timers
  p_one_target_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_reload) && $onehot0(wr_ctrl));

  // R2: without a read strobe the read data holds
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NUM_TMR = 4,
  parameter int DIV_W   = 11
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [$clog2(NUM_TMR):0]  haddr,
  input  logic                      wide,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  output logic [NUM_TMR-1:0]        irq
);
  localparam int ADDR_W = $clog2(NUM_TMR) + 1;

  logic [NUM_TMR-1:0][HALF_W-1:0] cnt_a, ctrl_a;
  logic [NUM_TMR-1:0]             wr_reload, wr_ctrl;
  logic [HALF_W-1:0]              reload_wdata, ctrl_wdata;
  logic [NUM_TMR:0]               casc;

  assign casc[0] = 1'b0;

  tmr_regif #(.NUM(NUM_TMR), .ADDR_W(ADDR_W)) i_regif (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .haddr        (haddr),
    .wide         (wide),
    .wdata        (wdata),
    .cnt_i        (cnt_a),
    .ctrl_i       (ctrl_a),
    .wr_reload    (wr_reload),
    .wr_ctrl      (wr_ctrl),
    .reload_wdata (reload_wdata),
    .ctrl_wdata   (ctrl_wdata),
    .rdata        (rdata)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    tmr_channel #(.DIV_W(DIV_W)) i_chan (
      .clk          (clk),
      .rst          (rst),
      .wr_reload    (wr_reload[g]),
      .wr_ctrl      (wr_ctrl[g]),
      .reload_wdata (reload_wdata),
      .ctrl_wdata   (ctrl_wdata),
      .casc_in      (casc[g]),
      .cnt_o        (cnt_a[g]),
      .ctrl_o       (ctrl_a[g]),
      .ovf_o        (casc[g+1]),
      .irq_o        (irq[g])
    );

    if (g > 0) begin : g_chk
      p_casc_step_r9: assert property (@(posedge clk) disable iff (rst)
        (casc[g] && ctrl_a[g][B_RUN] && ctrl_a[g][B_CAS] && !wr_ctrl[g] && cnt_a[g] != '1)
          |=> cnt_a[g] == $past(cnt_a[g]) + 1'b1);
    end
  end

  // R9: the overflow of the last timer only reaches its own request bit
  p_chain_end_r9: assert property (@(posedge clk) disable iff (rst)
    (casc[NUM_TMR] && ctrl_a[NUM_TMR-1][B_IE]) |=> irq[NUM_TMR-1]);
endmodule

// File: tb/test_tmr_bank.sv
module test_tmr_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  haddr = '0;
  logic        wide = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_bank i_tmr_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .haddr(haddr),
    .wide(wide), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all access tasks start and end at a falling edge
  task automatic wr16(input logic [2:0] a, input logic [15:0] d);
    haddr = a; wide = 1'b0; wdata = {16'h0, d}; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr32(input logic [1:0] t, input logic [15:0] c, input logic [15:0] r);
    haddr = {t, 1'b0}; wide = 1'b1; wdata = {c, r}; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic w, output logic [31:0] v);
    haddr = a; wide = w; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic t_reset;
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 irq", {28'h0, irq}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd({i[1:0], 1'b0}, 1'b1, got);
      chk("R1 timer word", got, 32'h0);
    end
  endtask

  task automatic t_fields;
    wr16(3'd1, 16'h7F03);
    rd(3'd1, 1'b0, got);
    chk("R4 masked control", got, 32'h0000_0003);
    wr16(3'd1, 16'h0000);
  endtask

  task automatic t_wrap_irq;
    logic seen;
    wr32(2'd0, 16'h00C0, 16'hFFFE);
    repeat (3) @(negedge clk);
    chk("R8 no early irq", {28'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq pulse", {28'h0, irq}, 32'h1);
    @(negedge clk);
    chk("R8 irq one cycle", {28'h0, irq}, 32'h0);
    rd(3'd0, 1'b0, got);
    chk("R7 reload after wrap", got, 32'h0000_FFFE);
    wr16(3'd1, 16'h0000);
    wr32(2'd0, 16'h0080, 16'hFFFE);
    seen = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (irq != 4'h0) seen = 1'b1;
    end
    chk("R8 no irq when disabled", {31'h0, seen}, 32'h0);
    wr16(3'd1, 16'h0000);
  endtask

  task automatic t_cascade;
    wr16(3'd2, 16'h1234);
    wr16(3'd3, 16'h0083);
    wr16(3'd3, 16'h0000);
    wr16(3'd3, 16'h0084);
    rd(3'd2, 1'b0, got);
    chk("R10 cascade start keeps count", got, 32'h0000_1234);
    wr32(2'd0, 16'h0080, 16'hFFFE);
    repeat (9) @(negedge clk);
    wr16(3'd1, 16'h0000);
    rd(3'd2, 1'b0, got);
    chk("R9 two lower overflows", got, 32'h0000_1236);
    rd(3'd2, 1'b1, got);
    chk("R2 wide read", got, 32'h0084_1236);
    wr16(3'd2, 16'h5555);
    rd(3'd2, 1'b0, got);
    chk("R3 reload write keeps count", got, 32'h0000_1236);
    wr16(3'd3, 16'h00C4);
    rd(3'd2, 1'b0, got);
    chk("R11 control rewrite no reload", got, 32'h0000_1236);
    wr16(3'd3, 16'h0000);
    wr16(3'd3, 16'h0083);
    rd(3'd2, 1'b0, got);
    chk("R5 start loads reload", got, 32'h0000_5555);
    wr16(3'd3, 16'h0000);
  endtask

  task automatic t_chain;
    for (int t = 1; t < 3; t++) begin
      wr16({t[1:0], 1'b0}, 16'hFFFF);
      wr16({t[1:0], 1'b1}, 16'h0083);
      wr16({t[1:0], 1'b1}, 16'h0000);
      wr16({t[1:0], 1'b1}, 16'h00C4);
    end
    wr16(3'd6, 16'h0010);
    wr16(3'd7, 16'h0083);
    wr16(3'd7, 16'h0000);
    wr16(3'd7, 16'h0084);
    wr32(2'd0, 16'h0080, 16'hFFFF);
    @(negedge clk);
    chk("R9 chain idle", {28'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 chained irqs same cycle", {28'h0, irq}, 32'h6);
    wr16(3'd1, 16'h0000);
    chk("R8 chained irqs drop", {28'h0, irq}, 32'h0);
    rd(3'd6, 1'b0, got);
    chk("R9 chain reaches top timer", got, 32'h0000_0011);
  endtask

  task automatic t_restart;
    wr16(3'd7, 16'h0000);
    rd(3'd6, 1'b0, got);
    chk("R6 stopped count", got, 32'h0000_0011);
    repeat (300) @(negedge clk);
    rd(3'd6, 1'b0, got);
    chk("R6 count frozen", got, 32'h0000_0011);
    wr16(3'd6, 16'h0100);
    wr16(3'd7, 16'h0081);
    repeat (60) @(negedge clk);
    wr16(3'd7, 16'h0000);
    wr16(3'd7, 16'h0081);
    repeat (127) @(negedge clk);
    rd(3'd6, 1'b0, got);
    chk("R6 R5 no step before full period", got, 32'h0000_0100);
    rd(3'd6, 1'b0, got);
    chk("R5 step at period", got, 32'h0000_0101);
    wr16(3'd7, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fields();
    t_wrap_irq();
    t_cascade();
    t_chain();
    t_restart();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule